// File: doc/BRIEF.md
# Serial CRC-8 Checker for 64-bit Identity Frames

This block computes an 8-bit cyclic redundancy check one bit per clock over a serial stream, using the generator x^8 + x^5 + x^4 + 1 in reflected, least-significant-bit-first form. A host clears the register, presents the bits of a frame on a one-bit port with a qualifying strobe, and reads the running check value at any time. A received 64-bit identity is accepted as intact when the register returns to zero after all 64 bits: the 56 payload bits (an 8-bit class code followed by a 48-bit serial field, each least significant bit first) and then the 8 check bits.

For hosts that hold whole bytes, a byte loader takes an 8-bit value and feeds it into the same register over the next eight cycles, least significant bit first. While it runs it raises a busy flag, and the direct bit port and further bytes are ignored. A flag tells the host whether the register currently holds zero, so frame validation needs no compare logic outside the block.

Top module: `crc8w_serial_unit`

## Requirements
- R1: After reset `crc_value` is 00h, `residue_zero` is 1 and `busy` is 0.
- R2: Each accepted bit d updates the register r as follows: t = r[0] XOR d; r is shifted right by one; if t is 1 the shifted value is XORed with 8Ch (t enters bit 7, taps at bits 3 and 2). From 00h a 1 bit gives 8Ch; from 8Ch a 0 bit gives 46h.
- R3: In a cycle with `bit_valid` low, `clear` low and `busy` low, the register keeps its value.
- R4: `clear` sets the register to 00h at the next clock edge and takes priority over `bit_valid` and `byte_valid` in the same cycle.
- R5: Starting from 00h, feeding the 56 payload bits of a frame least significant bit first leaves the frame's check value in the register.
- R6: Feeding the 56 payload bits followed by their 8 check bits (least significant bit first) leaves 00h; a frame with one corrupted bit leaves a nonzero value.
- R7: `residue_zero` is 1 exactly when `crc_value` is 00h, in the same cycle.
- R8: A `byte_valid` seen while `busy` is low is accepted at that edge; `busy` is then high for exactly 8 cycles, one bit of `byte_in` (bit 0 first) is applied per cycle, and the result equals applying those 8 bits through `bit_in`.
- R9: `byte_valid` while `busy` is high is ignored: the byte in progress finishes unchanged and no second byte starts.
- R10: `bit_valid` while `busy` is high is ignored; the result is that of the byte alone.
- R11: `clear` while `busy` is high aborts the byte: `busy` is low and the register 00h after the next edge, and nothing further is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of register and byte loader |
| bit_valid | input | 1 | Apply `bit_in` this cycle (ignored while busy) |
| bit_in | input | 1 | Serial data bit |
| byte_valid | input | 1 | Load `byte_in` into the byte loader (ignored while busy) |
| byte_in | input | 8 | Byte to feed, bit 0 first |
| busy | output | 1 | Byte loader is stepping |
| crc_value | output | 8 | Current register contents |
| residue_zero | output | 1 | High when `crc_value` is 00h |

## Verification
A bit presented with `bit_valid` is visible in `crc_value` one edge later, and `residue_zero` follows in the same cycle since it is combinational on the register. A byte accepted at edge N raises `busy` after that edge, and the final value appears after edge N+8 together with `busy` falling. The bench drives inputs on falling edges and samples on the falling edge after the edge that must carry the result, waiting exactly one or nine cycles as the case demands, and compares against its own byte-wise model of the reflected polynomial.

// File: rtl/crc8w_pkg.sv
package crc8w_pkg;
  localparam int unsigned CRC_W = 8;
  localparam logic [CRC_W-1:0] POLY_REFL = 8'h8C;

  // One reflected step: feedback into the top bit, taps folded by XOR.
  function automatic logic [CRC_W-1:0] crc8w_step(input logic [CRC_W-1:0] cur,
                                                  input logic din);
    logic fb;
    logic [CRC_W-1:0] nxt;
    fb  = cur[0] ^ din;
    nxt = cur >> 1;
    if (fb) nxt = nxt ^ POLY_REFL;
    return nxt;
  endfunction
endpackage

// File: rtl/crc8w_shift_reg.sv
module crc8w_shift_reg
  import crc8w_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             din,
  output logic [CRC_W-1:0] crc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= '0;
    else if (clear) crc_q <= '0;
    else if (step)  crc_q <= crc8w_step(crc_q, din);
  end

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_q == '0));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(crc_q));
  assert_one_from_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && step && din && crc_q == '0) |=> (crc_q == POLY_REFL));
  assert_zero_from_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && step && !din && crc_q == '0) |=> (crc_q == '0));
endmodule

// File: rtl/crc8w_byte_feed.sv
module crc8w_byte_feed #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [BYTE_W-1:0] data,
  output logic              busy,
  output logic              feed_step,
  output logic              feed_bit
);
  logic [BYTE_W-1:0] shreg_q;
  logic [CNT_W-1:0]  left_q;
  logic              accept;

  assign busy      = (left_q != '0);
  assign accept    = load && !busy && !clear;
  assign feed_step = busy;
  assign feed_bit  = shreg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      left_q  <= '0;
    end else if (clear) begin
      shreg_q <= '0;
      left_q  <= '0;
    end else if (accept) begin
      shreg_q <= data;
      left_q  <= CNT_W'(BYTE_W);
    end else if (busy) begin
      shreg_q <= shreg_q >> 1;
      left_q  <= left_q - 1'b1;
    end
  end

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_count_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clear) |=> (left_q == $past(left_q) - 1'b1));
  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !busy);
endmodule

// File: rtl/crc8w_serial_unit.sv
module crc8w_serial_unit
  import crc8w_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       bit_valid,
  input  logic       bit_in,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  output logic       busy,
  output logic [7:0] crc_value,
  output logic       residue_zero
);
  logic feed_step;
  logic feed_bit;
  logic core_step;
  logic core_din;

  crc8w_byte_feed #(.BYTE_W(8)) u_feed (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .load      (byte_valid),
    .data      (byte_in),
    .busy      (busy),
    .feed_step (feed_step),
    .feed_bit  (feed_bit)
  );

  // Loader owns the register while busy; the direct port is dropped then.
  assign core_step = busy ? feed_step : bit_valid;
  assign core_din  = busy ? feed_bit  : bit_in;

  crc8w_shift_reg u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .step  (core_step),
    .din   (core_din),
    .crc_q (crc_value)
  );

  assign residue_zero = (crc_value == '0);

  assert_busy_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> core_step);
  assert_flag_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !core_step && residue_zero) |=> residue_zero);
endmodule

// File: tb/test_crc8w_serial_unit.sv
module test_crc8w_serial_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       busy;
  logic [7:0] crc_value;
  logic       residue_zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  crc8w_serial_unit i_crc8w_serial_unit (
    .clk(clk), .rst_n(rst_n), .clear(clear), .bit_valid(bit_valid),
    .bit_in(bit_in), .byte_valid(byte_valid), .byte_in(byte_in),
    .busy(busy), .crc_value(crc_value), .residue_zero(residue_zero)
  );

  // Byte-wise model: XOR whole byte in, then eight shift/reduce rounds.
  function automatic logic [7:0] ref_byte(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] t;
    t = c ^ b;
    for (int k = 0; k < 8; k++) t = t[0] ? ((t >> 1) ^ 8'h8C) : (t >> 1);
    return t;
  endfunction

  function automatic logic [7:0] ref_bit(input logic [7:0] c, input logic d);
    logic [7:0] t;
    t = c ^ {7'b0, d};
    return t[0] ? ((t >> 1) ^ 8'h8C) : (t >> 1);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_valid = 1'b1; bit_in = b;
    @(negedge clk);
    bit_valid = 1'b0; bit_in = 1'b0;
  endtask

  task automatic send_byte_bits(input logic [7:0] b);
    for (int k = 0; k < 8; k++) send_bit(b[k]);
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 crc", crc_value, 8'h00);
    check("R1 residue", {7'b0, residue_zero}, 8'h01);
    check("R1 busy", {7'b0, busy}, 8'h00);
  endtask

  task automatic t_step_rule();
    do_clear();
    send_bit(1'b1);
    check("R2 one from zero", crc_value, 8'h8C);
    check("R7 flag low", {7'b0, residue_zero}, 8'h00);
    send_bit(1'b0);
    check("R2 zero from 8C", crc_value, 8'h46);
    repeat (3) @(negedge clk);
    check("R3 hold", crc_value, 8'h46);
    clear = 1'b1; bit_valid = 1'b1; bit_in = 1'b1; byte_valid = 1'b1; byte_in = 8'hFF;
    @(negedge clk);
    clear = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; byte_valid = 1'b0;
    check("R4 clear wins", crc_value, 8'h00);
    check("R4 no byte start", {7'b0, busy}, 8'h00);
    check("R7 flag high", {7'b0, residue_zero}, 8'h01);
  endtask

  task automatic t_frame(input logic [55:0] payload, input string tag);
    logic [7:0] exp;
    exp = 8'h00;
    for (int k = 0; k < 7; k++) exp = ref_byte(exp, payload[k*8 +: 8]);
    do_clear();
    for (int k = 0; k < 56; k++) send_bit(payload[k]);
    check({"R5 crc ", tag}, crc_value, exp);
    send_byte_bits(exp);
    check({"R6 residue ", tag}, crc_value, 8'h00);
    check({"R6 flag ", tag}, {7'b0, residue_zero}, 8'h01);
    do_clear();
    for (int k = 0; k < 56; k++) send_bit(payload[k] ^ (k == 20));
    send_byte_bits(exp);
    checks++;
    if (crc_value == 8'h00) begin
      errors++;
      $display("FAIL R6 corrupt %s actual=%h expected=nonzero", tag, crc_value);
    end
  endtask

  task automatic t_byte_path(input logic [7:0] b);
    logic [7:0] exp;
    do_clear();
    send_bit(1'b1);
    exp = ref_byte(8'h8C, b);
    byte_valid = 1'b1; byte_in = b;
    @(negedge clk);
    byte_valid = 1'b0;
    check("R8 busy up", {7'b0, busy}, 8'h01);
    repeat (7) @(negedge clk);
    check("R8 busy at 8th", {7'b0, busy}, 8'h01);
    @(negedge clk);
    check("R8 busy down", {7'b0, busy}, 8'h00);
    check("R8 byte result", crc_value, exp);
  endtask

  task automatic t_ignore_byte();
    do_clear();
    byte_valid = 1'b1; byte_in = 8'h5A;
    @(negedge clk);
    byte_in = 8'hC3;
    repeat (3) @(negedge clk);
    byte_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 busy done", {7'b0, busy}, 8'h00);
    check("R9 first byte only", crc_value, ref_byte(8'h00, 8'h5A));
    repeat (2) @(negedge clk);
    check("R9 no second byte", crc_value, ref_byte(8'h00, 8'h5A));
  endtask

  task automatic t_ignore_bits();
    do_clear();
    byte_valid = 1'b1; byte_in = 8'h3E;
    @(negedge clk);
    byte_valid = 1'b0;
    bit_valid = 1'b1; bit_in = 1'b1;
    repeat (8) @(negedge clk);
    bit_valid = 1'b0; bit_in = 1'b0;
    check("R10 bits ignored", crc_value, ref_byte(8'h00, 8'h3E));
  endtask

  task automatic t_abort();
    do_clear();
    byte_valid = 1'b1; byte_in = 8'hB7;
    @(negedge clk);
    byte_valid = 1'b0;
    repeat (3) @(negedge clk);
    do_clear();
    check("R11 busy dropped", {7'b0, busy}, 8'h00);
    check("R11 crc cleared", crc_value, 8'h00);
    repeat (6) @(negedge clk);
    check("R11 stays zero", crc_value, 8'h00);
  endtask

  task automatic t_bit_vs_byte_equiv();
    logic [7:0] exp;
    do_clear();
    send_byte_bits(8'hE1);
    exp = ref_bit(8'h00, 1'b1);
    for (int k = 1; k < 8; k++) exp = ref_bit(exp, 1'(8'hE1 >> k));
    check("R8 bits equal byte model", crc_value, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_step_rule();
    t_frame(56'h000001B81C02, "a");
    t_frame(56'hA5F0123456_7F28, "b");
    t_byte_path(8'h00);
    t_byte_path(8'h9D);
    t_ignore_byte();
    t_ignore_bits();
    t_abort();
    t_bit_vs_byte_equiv();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule